// File: doc/BRIEF.md
# Programmable Time-Base Interrupt Timer

This block is a free-running periodic divider clocked by the main oscillator. Each time a software-selected number of cycles has elapsed, it sets a status flag. It can raise an interrupt, so it serves as a regular real-time tick and as a wake-up source from a low-power state. Software reaches it through one 8-bit control/status register. The register carries a 2-bit period select, an interrupt enable and the event flag. Reading the register clears the flag.

The period select is double-buffered. A new value written by software takes effect only when the running period wraps, so the tick never slips. Two low-power inputs set how the timer behaves while the core sleeps:

- `halt` freezes both the counter and the register.
- `active_halt` freezes the register. The counter keeps running only if the interrupt is enabled, and a one-cycle `wake` pulse marks each enabled event.

The register port is a plain strobe interface with no handshake. A write or read completes in the cycle its strobe is high, and no back-pressure exists.

Top module: `tbt_timebase`

## Requirements
- R1: After reset, `rd_data` reads 8'h01: select 00, interrupt enable 0, flag 1. `irq` and `wake` are 0.
- R2: Period select values 00, 01, 10 and 11 give periods of `PER_0`, `PER_1`, `PER_2` and `PER_3` oscillator cycles (defaults 32000, 64000, 160000 and 400000). The period is the spacing between successive flag sets.
- R3: A new period select written mid-period leaves the current period at its old length. The new length applies from the following period onward.
- R4: The counter runs from 0 to N-1 and wraps to 0. The flag is set at the clock edge on which the counter holds N-1.
- R5: A read (`rd_en` high) clears the flag at that clock edge, unless R6 applies.
- R6: If the terminal count and a read land on the same edge, the flag ends set.
- R7: The register layout is bits 7:4 reserved (read 0), bits 3:2 period select, bit 1 interrupt enable and bit 0 flag. Only bits 3:1 are writable, and written values to bits 7:4 and bit 0 are ignored.
- R8: `irq` is high exactly while the flag is 1 and the interrupt enable is 1.
- R9: While `halt` is high, the counter and the register hold their values. Writes, clearing reads and flag sets are ignored, and counting resumes from the held value afterwards.
- R10: While `active_halt` is high with interrupt enable 1, the counter keeps its normal rhythm and the register stays frozen. `wake` pulses for one cycle after each terminal count.
- R11: While `active_halt` is high with interrupt enable 0, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_en | input | 1 | Register read strobe (clears flag) |
| rd_data | output | 8 | Current register contents |
| halt | input | 1 | Full halt: freeze counter and register |
| active_halt | input | 1 | Active halt: freeze register, count if enabled |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | One-cycle wake pulse from active halt |

## Verification
A wrong counter limit or a wrong active selection shows up as a flag spacing that differs from the selected period. The error is visible on the first event after the bad state, which is at most one period later. A broken deferral shows up in the very period during which the write happened, because that period comes out with the new length. A wrong priority between set and clear, or a freeze that leaks, shows in `rd_data[0]` or `rd_data[3:1]` one cycle after the offending edge. The bench measures flag spacing edge by edge under every select, at select changes, and inside halt windows of both kinds.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

  typedef logic [1:0] tb_sel_t;

  typedef struct packed {
    logic [3:0] rsvd;
    tb_sel_t    sel;
    logic       oie;
    logic       flag;
  } csr_t;

  localparam csr_t CSR_RESET = '{rsvd: 4'h0, sel: 2'b00, oie: 1'b0, flag: 1'b1};

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/tbt_period_sel.sv
module tbt_period_sel
  import tbt_pkg::*;
#(
  parameter int unsigned PER_0 = 32000,
  parameter int unsigned PER_1 = 64000,
  parameter int unsigned PER_2 = 160000,
  parameter int unsigned PER_3 = 400000,
  parameter int unsigned CW    = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  tb_sel_t       next_sel,
  output tb_sel_t       act_sel,
  output logic [CW-1:0] term_val
);

  localparam int unsigned NSEL = 4;
  localparam int unsigned PTAB [NSEL] = '{PER_0, PER_1, PER_2, PER_3};

  logic [CW-1:0] lim [NSEL];
  tb_sel_t       sel_q;

  // One terminal value per select code.
  for (genvar i = 0; i < NSEL; i++) begin : g_lim
    assign lim[i] = CW'(PTAB[i] - 1);
  end

  // The active selection changes only on the wrap.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= '0;
    else if (load) sel_q <= next_sel;
  end

  assign act_sel  = sel_q;
  assign term_val = lim[sel_q];

endmodule

// File: rtl/tbt_counter.sv
module tbt_counter #(
  parameter int unsigned CW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] term_val,
  output logic [CW-1:0] cnt,
  output logic          tick
);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == term_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else if (run)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/tbt_csr.sv
module tbt_csr
  import tbt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       freeze,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic       tick,
  output tb_sel_t    sel,
  output logic       oie,
  output logic       flag,
  output logic [7:0] rd_data
);

  csr_t csr_q;
  csr_t wr_view;

  assign wr_view = csr_t'(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q <= CSR_RESET;
    end else if (!freeze) begin
      if (wr_en) begin
        csr_q.sel <= wr_view.sel;
        csr_q.oie <= wr_view.oie;
      end
      // The hardware set takes precedence over the clearing read.
      if (tick)       csr_q.flag <= 1'b1;
      else if (rd_en) csr_q.flag <= 1'b0;
    end
  end

  assign sel     = csr_q.sel;
  assign oie     = csr_q.oie;
  assign flag    = csr_q.flag;
  assign rd_data = {4'h0, csr_q.sel, csr_q.oie, csr_q.flag};

endmodule

// File: rtl/tbt_timebase.sv
module tbt_timebase
  import tbt_pkg::*;
#(
  parameter int unsigned PER_0 = 32000,
  parameter int unsigned PER_1 = 64000,
  parameter int unsigned PER_2 = 160000,
  parameter int unsigned PER_3 = 400000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       halt,
  input  logic       active_halt,
  output logic       irq,
  output logic       wake
);

  localparam int unsigned MAXP = max_of4(PER_0, PER_1, PER_2, PER_3);
  localparam int unsigned CW   = (MAXP > 2) ? $clog2(MAXP) : 1;

  tb_sel_t       sw_sel;
  tb_sel_t       act_sel;
  logic          oie;
  logic          flag;
  logic          run;
  logic          freeze;
  logic          tick;
  logic [CW-1:0] cnt;
  logic [CW-1:0] term_val;
  logic          wake_q;

  // Full halt stops everything; active halt keeps counting only when enabled.
  assign freeze = halt || active_halt;
  assign run    = !halt && (!active_halt || oie);

  tbt_period_sel #(
    .PER_0(PER_0), .PER_1(PER_1), .PER_2(PER_2), .PER_3(PER_3), .CW(CW)
  ) u_psel (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tick),
    .next_sel (sw_sel),
    .act_sel  (act_sel),
    .term_val (term_val)
  );

  tbt_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .term_val (term_val),
    .cnt      (cnt),
    .tick     (tick)
  );

  tbt_csr u_csr (
    .clk     (clk),
    .rst_n   (rst_n),
    .freeze  (freeze),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .tick    (tick),
    .sel     (sw_sel),
    .oie     (oie),
    .flag    (flag),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= tick && active_halt && !halt;
  end

  assign wake = wake_q;
  assign irq  = flag && oie;

endmodule

// File: rtl/tbt_timebase_chk.sv
module tbt_timebase_chk #(
  parameter int unsigned CW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic [7:0]    rd_data,
  input logic          halt,
  input logic          active_halt,
  input logic          wake,
  input logic          tick,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] term_val,
  input logic [1:0]    act_sel
);

  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= term_val);

  // R3
  sel_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(act_sel));

  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !halt && !active_halt && !tick) |=> !rd_data[0]);

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !halt && !active_halt) |=> rd_data[0]);

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> ($stable(rd_data) && $stable(cnt)));

  // R10
  wake_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(active_halt));

endmodule

bind tbt_timebase tbt_timebase_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_en       (rd_en),
  .rd_data     (rd_data),
  .halt        (halt),
  .active_halt (active_halt),
  .wake        (wake),
  .tick        (tick),
  .cnt         (cnt),
  .term_val    (term_val),
  .act_sel     (act_sel)
);

// File: tb/tbt_timebase_bench.sv
module tbt_timebase_bench;

  localparam int P0 = 8;
  localparam int P1 = 12;
  localparam int P2 = 20;
  localparam int P3 = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic       halt = 1'b0;
  logic       active_halt = 1'b0;
  logic [7:0] rd_data;
  logic       irq;
  logic       wake;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  tbt_timebase #(.PER_0(P0), .PER_1(P1), .PER_2(P2), .PER_3(P3)) u_tbt_timebase (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .halt(halt), .active_halt(active_halt), .irq(irq), .wake(wake)
  );

  // Each entry: write value, expected readback of bits 7:1 (R7).
  localparam logic [15:0] VEC [7] = '{
    {8'hFF, 8'h0E}, {8'hF0, 8'h00}, {8'h0A, 8'h0A}, {8'h05, 8'h04},
    {8'h0C, 8'h0C}, {8'hF3, 8'h02}, {8'h02, 8'h02}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // Called at a negedge where the flag is 1. Reads to clear it, then counts
  // edges until the flag is seen again. An optional write lands on edge wr_at,
  // and an optional freeze window covers edges fz_from .. fz_from+fz_len-1.
  task automatic measure(output int n, input int wr_at, input logic [7:0] wdat,
                         input int fz_from, input int fz_len, input bit use_ah);
    int c;
    c = 0;
    rd_en = 1'b1;
    forever begin
      @(negedge clk);
      c++;
      rd_en = 1'b0;
      wr_en = 1'b0;
      halt = 1'b0;
      active_halt = 1'b0;
      if (rd_data[0] || c > 2000) break;
      if (c == wr_at) begin
        wr_en = 1'b1;
        wr_data = wdat;
      end
      if (c >= fz_from && c < fz_from + fz_len) begin
        if (use_ah) active_halt = 1'b1;
        else        halt = 1'b1;
      end
    end
    n = c;
  endtask

  task automatic wr_reg(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  int n;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_data == 8'h01, "R1 rd_data", rd_data, 8'h01);
    chk(irq == 1'b0 && wake == 1'b0, "R1 irq/wake", {irq, wake}, 0);
    rst_n = 1'b1;

    // R7 writable-bit table
    for (int i = 0; i < 7; i++) begin
      wr_reg(VEC[i][15:8]);
      chk(rd_data[7:1] == VEC[i][7:1], "R7 writable bits", rd_data[7:1], VEC[i][7:1]);
    end

    // Settle on select 00 with the interrupt enabled.
    while (!rd_data[0]) @(negedge clk);
    measure(n, 0, 8'h00, 0, 0, 1'b0);
    measure(n, 0, 8'h00, 0, 0, 1'b0);
    measure(n, 0, 8'h00, 0, 0, 1'b0);
    chk(n == P0, "R2 R4 period sel 00", n, P0);
    // R8 irq follows flag and enable
    chk(irq == 1'b1, "R8 irq with flag and enable", irq, 1);

    // R3 deferred switch 00 -> 10
    measure(n, 3, 8'h0A, 0, 0, 1'b0);
    chk(n == P0, "R3 old period kept", n, P0);
    measure(n, 0, 8'h00, 0, 0, 1'b0);
    chk(n == P2, "R2 R3 period sel 10", n, P2);
    measure(n, 5, 8'h0E, 0, 0, 1'b0);
    chk(n == P2, "R3 old period kept", n, P2);
    measure(n, 0, 8'h00, 0, 0, 1'b0);
    chk(n == P3, "R2 period sel 11", n, P3);
    measure(n, 4, 8'h06, 0, 0, 1'b0);
    chk(n == P3, "R3 old period kept", n, P3);
    measure(n, 0, 8'h00, 0, 0, 1'b0);
    chk(n == P1, "R2 period sel 01", n, P1);
    measure(n, 2, 8'h02, 0, 0, 1'b0);
    measure(n, 0, 8'h00, 0, 0, 1'b0);
    chk(n == P0, "R2 back to sel 00", n, P0);

    // R6 read colliding with the terminal count
    rd_en = 1'b1;
    for (int c = 1; c <= P0; c++) begin
      @(negedge clk);
      rd_en = (c == P0 - 1);
      if (c == 1) chk(rd_data[0] == 1'b0, "R5 read clears flag", rd_data[0], 0);
    end
    chk(rd_data[0] == 1'b1, "R6 set wins over clear", rd_data[0], 1);

    // R9 halt with a write and a read: nothing changes
    halt = 1'b1;
    wr_en = 1'b1;
    wr_data = 8'h0C;
    rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    chk(rd_data == 8'h03, "R9 register frozen in halt", rd_data, 8'h03);
    halt = 1'b0;
    measure(n, 0, 8'h00, 0, 0, 1'b0);
    chk(n == P0, "R9 phase kept across halt", n, P0);

    // R9 halt window stretches the period
    measure(n, 0, 8'h00, 2, 5, 1'b0);
    chk(n == P0 + 5, "R9 counter frozen in halt", n, P0 + 5);

    // R7 bit 0 write of 0 ignored while flag is 1
    wr_en = 1'b1;
    wr_data = 8'hF2;
    @(negedge clk);
    wr_en = 1'b0;
    chk(rd_data == 8'h03, "R7 bit0 and reserved ignored", rd_data, 8'h03);
    measure(n, 0, 8'h00, 0, 0, 1'b0);
    measure(n, 0, 8'h00, 0, 0, 1'b0);

    // R11 active halt with enable 0 freezes the counter
    measure(n, 1, 8'h00, 3, 4, 1'b1);
    chk(n == P0 + 4, "R11 counter frozen", n, P0 + 4);
    chk(irq == 1'b0, "R8 irq masked by enable", irq, 0);
    // re-enable; this period is unaffected
    measure(n, 1, 8'h02, 0, 0, 1'b0);
    chk(n == P0, "R8 R11 period after re-enable", n, P0);

    // R10 active halt with enable 1: counter runs, flag frozen, wake pulses
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    active_halt = 1'b1;
    n = 1;
    while (!wake && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(n == P0, "R10 wake timing", n, P0);
    chk(rd_data[0] == 1'b0 && irq == 1'b0, "R10 flag frozen", rd_data[0], 0);
    active_halt = 1'b0;
    @(negedge clk);
    chk(wake == 1'b0, "R10 single wake pulse", wake, 0);
    chk(rd_data[0] == 1'b0, "R10 event not latched", rd_data[0], 0);

    finish_run();
  end

endmodule